// File: doc/BRIEF.md
# Merging Store Buffer with Read Bypass

This block sits between a write-through cache and the memory port. Processor stores are accepted in the cycle they arrive and held in a small set of line-wide entries, so the processor never waits for a memory write to finish. A store whose line address matches an entry that is still waiting merges its bytes into that entry. A store to any other line takes a free entry. Entries go to memory as one transaction each, carrying the whole line and a byte mask. This turns a run of word stores to one line into a single wide write.

Read misses from the cache pass through the same block. A read that no entry covers goes to memory ahead of writes that have not yet been presented. A read that an entry covers completely is answered from the buffer. A read that an entry covers only in part is held back. Entries then drain in order until the conflicting one has left, so the read can never return stale memory contents.

The memory port is shared. Only one transaction, read or write, is presented at a time. A presented write stays in place until memory accepts it.

Top module: `wbMergeTop`

## Requirements
- R1: A store is taken (stReady high while stValid is high) in the cycle it can be captured, whatever memReady is doing. Stores keep being accepted while memory stalls.
- R2: A store whose line address (address bits 31:4) matches a waiting entry writes its enabled bytes into that entry and does not take a new one. No two entries ever hold the same line. Four word stores to one line leave memory as one write with all 16 byte enables set and word i in bits 32i+31:32i.
- R3: Entries are written to memory in the order they were allocated.
- R4: When all four entries are in use, a store that matches none of them sees stReady low. A store that matches a non-draining entry is still accepted.
- R5: A memory write presents memWrite=1, a line-aligned memAddr (bits 3:0 zero), the 128-bit line in memWData and a 16-bit byte mask in memBe (bit j = byte j of the line). These values stay stable until memReady is seen high.
- R6: A read whose 4-byte word is fully held by an entry raises fwdValid and rdReady in the same cycle, with that word on fwdData, and starts no memory read.
- R7: A read that matches no entry is presented to memory (memValid=1, memWrite=0, memAddr=rdAddr) ahead of entries not yet presented. rdReady rises in the cycle memReady accepts it.
- R8: A read whose line matches an entry that lacks some of the requested bytes gets no memory read and no rdReady. Entries drain in order until that entry is gone, and then the read goes to memory.
- R9: An entry being presented to memory accepts no merges. A store to its line is stalled with stReady low.
- R10: The oldest entry is drained when its line is fully written, or when another entry waits behind it, or when a read partly overlaps it. Otherwise it is drained once 8 clock cycles have passed with entries held and no store accepted.
- R11: After reset the buffer is empty: stReady is high, and memValid, rdReady and fwdValid are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stValid | input | 1 | Store request present |
| stReady | output | 1 | Store captured this cycle |
| stAddr | input | 32 | Store byte address, word aligned |
| stData | input | 32 | Store data word |
| stBe | input | 4 | Store byte enables |
| rdValid | input | 1 | Read-miss request present |
| rdReady | output | 1 | Read resolved (forwarded or accepted by memory) |
| rdAddr | input | 32 | Read byte address, word aligned |
| fwdValid | output | 1 | Read data supplied from the buffer |
| fwdData | output | 32 | Forwarded word |
| memValid | output | 1 | Memory transaction presented |
| memReady | input | 1 | Memory accepts the presented transaction |
| memWrite | output | 1 | 1 = line write, 0 = word read |
| memAddr | output | 32 | Line address for writes, word address for reads |
| memWData | output | 128 | Write line data |
| memBe | output | 16 | Write byte mask |

## Verification
The bench fills one line word by word while memory stalls and checks that it leaves as a single full-mask write. A design that failed to merge would show extra writes or a partial mask. It then stores to the line already on the memory port and expects a stall; a design that merged there would change a write already presented. Reads are driven at a fully held word, at a missing word of a held line, and at an unheld line while writes are waiting. These catch, in turn, a design that reads stale memory, one that forwards bytes it never received, and one that lets writes starve reads. Finally the buffer is filled to capacity to show that a new line is refused while a merge into a queued line still succeeds, and a lone partial entry is timed to the exact cycle its idle drain starts.

// File: rtl/wbPkg.sv
package wbPkg;
  timeunit 1ns; timeprecision 1ps;

  localparam int ENTRIES     = 4;   // power of two (ring pointers wrap)
  localparam int WORDS       = 4;
  localparam int WORD_W      = 32;
  localparam int ADDR_W      = 32;
  localparam int HOLD_CYCLES = 8;

  localparam int IDX_W      = $clog2(ENTRIES);
  localparam int CNT_W      = $clog2(ENTRIES + 1);
  localparam int BPW        = WORD_W / 8;
  localparam int BSEL_LO    = $clog2(BPW);
  localparam int LINE_BYTES = WORDS * BPW;
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int TAG_W      = ADDR_W - OFF_W;
  localparam int HOLD_W     = $clog2(HOLD_CYCLES + 1);

  typedef struct packed {
    logic             wrEn;
    logic             newEntry;
    logic [IDX_W-1:0] wrIdx;
    logic             retire;
    logic [IDX_W-1:0] headIdx;
  } strobes_t;
endpackage

// File: rtl/wbData.sv
module wbData
  import wbPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              stb,
  input  logic [ADDR_W-1:0]     stAddr,
  input  logic [WORD_W-1:0]     stData,
  input  logic [BPW-1:0]        stBe,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [ENTRIES-1:0]    entValid,
  output logic [ENTRIES-1:0]    entFull,
  output logic [ENTRIES-1:0]    stHit,
  output logic [ENTRIES-1:0]    rdHit,
  output logic                  rdCover,
  output logic [WORD_W-1:0]     fwdData,
  output logic [TAG_W-1:0]      headTag,
  output logic [LINE_W-1:0]     headLine,
  output logic [LINE_BYTES-1:0] headBe
);
  timeunit 1ns; timeprecision 1ps;

  logic [TAG_W-1:0]      tagQ  [ENTRIES];
  logic [LINE_W-1:0]     lineQ [ENTRIES];
  logic [LINE_BYTES-1:0] beQ   [ENTRIES];
  logic [ENTRIES-1:0]    validQ;

  logic [OFF_W-BSEL_LO-1:0] stWord, rdWord;
  logic [LINE_BYTES-1:0]    placeBe;
  logic [LINE_W-1:0]        placeData;
  logic                     unusedLowBits;

  assign stWord        = stAddr[OFF_W-1:BSEL_LO];
  assign rdWord        = rdAddr[OFF_W-1:BSEL_LO];
  assign placeBe       = LINE_BYTES'(stBe) << (stWord * BPW);
  assign placeData     = LINE_W'(stData) << (stWord * WORD_W);
  assign unusedLowBits = ^{stAddr[BSEL_LO-1:0], rdAddr[BSEL_LO-1:0]};

  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    assign stHit[g]   = validQ[g] && (tagQ[g] == stAddr[ADDR_W-1:OFF_W]);
    assign rdHit[g]   = validQ[g] && (tagQ[g] == rdAddr[ADDR_W-1:OFF_W]);
    assign entFull[g] = &beQ[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        tagQ[e]  <= '0;
        lineQ[e] <= '0;
        beQ[e]   <= '0;
      end
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (stb.wrEn && stb.wrIdx == IDX_W'(e)) begin
          if (stb.newEntry) begin
            validQ[e] <= 1'b1;
            tagQ[e]   <= stAddr[ADDR_W-1:OFF_W];
            lineQ[e]  <= placeData;
            beQ[e]    <= placeBe;
          end else begin
            beQ[e] <= beQ[e] | placeBe;
            for (int b = 0; b < LINE_BYTES; b++)
              if (placeBe[b]) lineQ[e][b*8 +: 8] <= placeData[b*8 +: 8];
          end
        end else if (stb.retire && stb.headIdx == IDX_W'(e)) begin
          validQ[e] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rdCover = 1'b0;
    fwdData = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (rdHit[e]) begin
        rdCover = &beQ[e][rdWord*BPW +: BPW];
        fwdData = lineQ[e][rdWord*WORD_W +: WORD_W];
      end
    end
  end

  assign entValid = validQ;
  assign headTag  = tagQ[stb.headIdx];
  assign headLine = lineQ[stb.headIdx];
  assign headBe   = beQ[stb.headIdx];
endmodule

// File: rtl/wbCtrl.sv
module wbCtrl
  import wbPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               stValid,
  input  logic               rdValid,
  input  logic               memReady,
  input  logic [ENTRIES-1:0] entValid,
  input  logic [ENTRIES-1:0] entFull,
  input  logic [ENTRIES-1:0] stHit,
  input  logic [ENTRIES-1:0] rdHit,
  input  logic               rdCover,
  output strobes_t           stb,
  output logic               stReady,
  output logic               rdReady,
  output logic               fwdValid,
  output logic               memValid,
  output logic               memWrite
);
  timeunit 1ns; timeprecision 1ps;

  logic [IDX_W-1:0]  headQ, tailQ, hitIdx;
  logic [CNT_W-1:0]  countQ;
  logic [HOLD_W-1:0] idleQ;
  logic              drainBusyQ;
  logic anyStHit, rdFull, rdPartial, rdMiss, drainWant;
  logic presentWrite, presentRead, accept, alloc, retire;

  always_comb begin
    hitIdx = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (stHit[e]) hitIdx = IDX_W'(e);
  end

  assign anyStHit  = |stHit;
  assign rdFull    = rdValid && (|rdHit) && rdCover;
  assign rdPartial = rdValid && (|rdHit) && !rdCover;
  assign rdMiss    = rdValid && !(|rdHit);

  // oldest entry asks for memory under any of the drain triggers
  assign drainWant = entValid[headQ] &&
                     (drainBusyQ || entFull[headQ] || countQ > CNT_W'(1) ||
                      idleQ == HOLD_W'(HOLD_CYCLES) || rdPartial);

  // a presented write is held; otherwise a clean read miss wins the port
  assign presentWrite = drainBusyQ || (!rdMiss && drainWant);
  assign presentRead  = rdMiss && !drainBusyQ;

  assign memValid = presentWrite || presentRead;
  assign memWrite = presentWrite;
  assign fwdValid = rdFull;
  assign rdReady  = rdFull || (presentRead && memReady);

  assign stReady = anyStHit ? !(presentWrite && hitIdx == headQ)
                            : (countQ < CNT_W'(ENTRIES));
  assign accept  = stValid && stReady;
  assign alloc   = accept && !anyStHit;
  assign retire  = presentWrite && memReady;

  always_comb begin
    stb.wrEn     = accept;
    stb.newEntry = !anyStHit;
    stb.wrIdx    = anyStHit ? hitIdx : tailQ;
    stb.retire   = retire;
    stb.headIdx  = headQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ      <= '0;
      tailQ      <= '0;
      countQ     <= '0;
      drainBusyQ <= 1'b0;
      idleQ      <= '0;
    end else begin
      if (retire) headQ <= headQ + 1'b1;
      if (alloc)  tailQ <= tailQ + 1'b1;
      countQ     <= countQ + CNT_W'(alloc) - CNT_W'(retire);
      drainBusyQ <= presentWrite && !memReady;
      if (accept || countQ == '0)               idleQ <= '0;
      else if (idleQ != HOLD_W'(HOLD_CYCLES))  idleQ <= idleQ + 1'b1;
    end
  end
endmodule

// File: rtl/wbMergeTop.sv
module wbMergeTop
  import wbPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  stValid,
  output logic                  stReady,
  input  logic [ADDR_W-1:0]     stAddr,
  input  logic [WORD_W-1:0]     stData,
  input  logic [BPW-1:0]        stBe,
  input  logic                  rdValid,
  output logic                  rdReady,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic                  fwdValid,
  output logic [WORD_W-1:0]     fwdData,
  output logic                  memValid,
  input  logic                  memReady,
  output logic                  memWrite,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [LINE_W-1:0]     memWData,
  output logic [LINE_BYTES-1:0] memBe
);
  timeunit 1ns; timeprecision 1ps;

  strobes_t              stb;
  logic [ENTRIES-1:0]    entValid, entFull, stHit, rdHit;
  logic                  rdCover;
  logic [TAG_W-1:0]      headTag;
  logic [LINE_BYTES-1:0] headBe;

  wbData uData (
    .clk(clk), .rstN(rstN), .stb(stb),
    .stAddr(stAddr), .stData(stData), .stBe(stBe), .rdAddr(rdAddr),
    .entValid(entValid), .entFull(entFull), .stHit(stHit), .rdHit(rdHit),
    .rdCover(rdCover), .fwdData(fwdData),
    .headTag(headTag), .headLine(memWData), .headBe(headBe)
  );

  wbCtrl uCtrl (
    .clk(clk), .rstN(rstN), .stValid(stValid), .rdValid(rdValid),
    .memReady(memReady), .entValid(entValid), .entFull(entFull),
    .stHit(stHit), .rdHit(rdHit), .rdCover(rdCover), .stb(stb),
    .stReady(stReady), .rdReady(rdReady), .fwdValid(fwdValid),
    .memValid(memValid), .memWrite(memWrite)
  );

  assign memAddr = memWrite ? {headTag, {OFF_W{1'b0}}} : rdAddr;
  assign memBe   = memWrite ? headBe : '0;
endmodule

// File: rtl/wbChecker.sv
module wbChecker
  import wbPkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  stValid,
  input logic                  stReady,
  input logic                  rdValid,
  input logic                  fwdValid,
  input logic                  memValid,
  input logic                  memWrite,
  input logic                  memReady,
  input logic [ADDR_W-1:0]     memAddr,
  input logic [LINE_BYTES-1:0] memBe,
  input logic [ENTRIES-1:0]    entValid,
  input logic [ENTRIES-1:0]    stHit,
  input logic [ENTRIES-1:0]    rdHit
);
  timeunit 1ns; timeprecision 1ps;

  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memWrite && !memReady |=> memValid && memWrite && $stable(memAddr) && $stable(memBe)); // R5
  AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memWrite |-> memAddr[OFF_W-1:0] == '0 && memBe != '0); // R5
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rstN)
    stValid && (&entValid) && !(|stHit) |-> !stReady); // R4
  AST_UNIQUE_LINE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stHit)); // R2
  AST_FWD_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> !(memValid && !memWrite)); // R6
  AST_PARTIAL_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && (|rdHit) && !fwdValid |-> !(memValid && !memWrite)); // R8
endmodule

bind wbMergeTop wbChecker uChk (
  .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady),
  .rdValid(rdValid), .fwdValid(fwdValid), .memValid(memValid),
  .memWrite(memWrite), .memReady(memReady), .memAddr(memAddr),
  .memBe(memBe), .entValid(entValid), .stHit(stHit), .rdHit(rdHit)
);

// File: tb/tb_wbMergeTop.sv
module tb_wbMergeTop;
  timeunit 1ns; timeprecision 1ps;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         stValid = 1'b0, rdValid = 1'b0, memReady = 1'b0;
  logic [31:0]  stAddr = '0, stData = '0, rdAddr = '0;
  logic [3:0]   stBe = '0;
  logic         stReady, rdReady, fwdValid, memValid, memWrite;
  logic [31:0]  fwdData, memAddr;
  logic [127:0] memWData;
  logic [15:0]  memBe;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;   // 8 ns period

  wbMergeTop dut (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady),
    .stAddr(stAddr), .stData(stData), .stBe(stBe),
    .rdValid(rdValid), .rdReady(rdReady), .rdAddr(rdAddr),
    .fwdValid(fwdValid), .fwdData(fwdData),
    .memValid(memValid), .memReady(memReady), .memWrite(memWrite),
    .memAddr(memAddr), .memWData(memWData), .memBe(memBe)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] data;
    logic        expRdy;
  } vec_t;

  // memory held off: four word stores fill line 0x100, a fifth hits the
  // line now on the memory port, a sixth opens line 0x200
  localparam vec_t VEC [6] = '{
    '{32'h0000_0100, 32'h1111_1111, 1'b1},
    '{32'h0000_0104, 32'h2222_2222, 1'b1},
    '{32'h0000_0108, 32'h3333_3333, 1'b1},
    '{32'h0000_010C, 32'h4444_4444, 1'b1},
    '{32'h0000_0104, 32'h5555_5555, 1'b0},
    '{32'h0000_0200, 32'hAAAA_AAAA, 1'b1}
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic nextSample();
    @(negedge clk);
    #2;
  endtask

  task automatic waitMem();
    for (int k = 0; k < 20; k++) begin
      if (memValid) break;
      nextSample();
    end
  endtask

  task automatic store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    stValid = 1'b1; stAddr = a; stData = d; stBe = be;
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    check("R11 stReady", stReady, 1);
    check("R11 memValid", memValid, 0);
    check("R11 rdReady", rdReady, 0);
    check("R11 fwdValid", fwdValid, 0);

    // table walk: R1, R2, R9
    for (int i = 0; i < 6; i++) begin
      store(VEC[i].addr, VEC[i].data, 4'hF);
      check(VEC[i].expRdy ? "R1/R2 store accepted" : "R9 store to draining line",
            stReady, VEC[i].expRdy);
    end

    nextSample();
    stValid = 1'b0; memReady = 1'b1;
    #1;
    check("R2/R5 merged write", memValid && memWrite, 1);
    check("R5 line addr", memAddr, 32'h100);
    check("R2 full mask", memBe, 16'hFFFF);
    check("R2 line data", memWData, 128'h44444444_33333333_22222222_11111111);

    // R6 forward from buffer
    @(negedge clk); rdValid = 1'b1; rdAddr = 32'h200; #2;
    check("R6 fwdValid", fwdValid, 1);
    check("R6 fwdData", fwdData, 32'hAAAA_AAAA);
    check("R6 rdReady", rdReady, 1);
    check("R6 no memory access", memValid, 0);

    // R8 partial overlap drains first
    @(negedge clk); rdAddr = 32'h204; #2;
    check("R8 drain write", memValid && memWrite, 1);
    check("R8 drain addr", memAddr, 32'h200);
    check("R8 drain mask", memBe, 16'h000F);
    check("R8 read held", rdReady, 0);
    nextSample();
    check("R8 read issued", memValid && !memWrite, 1);
    check("R8 read addr", memAddr, 32'h204);
    check("R8 rdReady", rdReady, 1);
    @(negedge clk); rdValid = 1'b0;

    // R10 idle drain timing
    store(32'h300, 32'h3030_3030, 4'hF);
    @(negedge clk); stValid = 1'b0; #2;
    check("R10 idle 0", memValid, 0);
    for (int i = 1; i <= 8; i++) begin
      nextSample();
      check("R10 idle drain timing", memValid, (i == 8));
    end

    // R7 read ahead of queued writes
    store(32'h400, 32'h4040_4040, 4'hF);
    store(32'h500, 32'h5050_5050, 4'hF);
    @(negedge clk); stValid = 1'b0; rdValid = 1'b1; rdAddr = 32'h600; #2;
    check("R7 read first", memValid && !memWrite, 1);
    check("R7 read addr", memAddr, 32'h600);
    check("R7 rdReady", rdReady, 1);
    @(negedge clk); rdValid = 1'b0; #2;
    waitMem();
    check("R3 first write", memAddr, 32'h400);
    nextSample(); waitMem();
    check("R3 second write", memAddr, 32'h500);
    nextSample();
    check("R3 empty", memValid, 0);

    // R4 full buffer
    memReady = 1'b0;
    store(32'h700, 32'h7, 4'hF); check("R4 fill 0", stReady, 1);
    store(32'h800, 32'h8, 4'hF); check("R4 fill 1", stReady, 1);
    store(32'h900, 32'h9, 4'hF); check("R4 fill 2", stReady, 1);
    store(32'hA00, 32'hA, 4'hF); check("R4 fill 3", stReady, 1);
    store(32'hB00, 32'hB, 4'hF); check("R4 full stall", stReady, 0);
    check("R5 write held", memAddr, 32'h700);
    store(32'h904, 32'h99, 4'hF); check("R4 merge while full", stReady, 1);
    @(negedge clk); stValid = 1'b0; memReady = 1'b1; #2;
    waitMem();
    check("R3 order 0", memAddr, 32'h700);
    nextSample(); waitMem();
    check("R3 order 1", memAddr, 32'h800);
    nextSample(); waitMem();
    check("R3 order 2", memAddr, 32'h900);
    check("R2 merged mask", memBe, 16'h00FF);
    nextSample(); waitMem();
    check("R3 order 3", memAddr, 32'hA00);
    nextSample();
    check("R3 drained", memValid, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule